// File: doc/BRIEF.md
# Sensor Serial Register Port

This block is the host-facing serial port of a motion sensor. An external controller drives a four-wire SPI link: clock, data in, data out and an active-low select. The controller opens every exchange, and the port never starts one. The port samples the three inbound lines through synchronisers into the system clock domain and decodes the bit stream into register accesses. It issues one-cycle strobes on a simple internal register bus.

The same link carries four kinds of exchange. A register write sends a command byte and then a data byte. A register read sends a command byte, waits a programmable number of system clocks, and then returns one byte. A motion burst returns consecutive motion registers for as long as select stays low. A firmware download sends every byte that follows its command to a memory write port.

The port stays silent while the power-down input is low or the chip-reset input is high. Raising select at any point throws away the exchange in progress. A minimum idle gap is enforced between exchanges, and it also applies after an abort.

Top module: `sspi_regport`

## Requirements
- R1: After system reset `spi_sdo_en`, `busy`, `reg_wr`, `reg_rd` and `mem_we` are all low.
- R2: Every exchange opens with a command byte, sent most significant bit first. Bit 7 = 1 marks a write and bits 6:0 give the register address. For an ordinary address the next byte produces exactly one `reg_wr` pulse carrying that address and that byte.
- R3: A command byte with bit 7 = 0 is a read. After READ_WAIT system clocks the port raises one `reg_rd` pulse with that address. It shifts out the `reg_rdata` value seen during the pulse, MSB first. Data out changes after falling clock edges so that the host can sample on rising edges (mode 3, clock idle high).
- R4: `busy` is high during the read wait, and serial clock edges that arrive while it is high are ignored.
- R5: A write command to address 0x50 (no data byte follows) starts a burst. After the read wait the port returns registers MOTION_BASE (0x02) onward in order. It wraps back after MOTION_LEN (4) registers and continues until select rises.
- R6: A write command to address 0x62 starts a download. Each complete following byte gives one `mem_we` pulse with that byte, until select rises. A partial final byte is dropped.
- R7: Raising select in the middle of any exchange discards it, and no strobe is produced for the unfinished byte.
- R8: After any exchange ends or is aborted, select must stay high for GAP_CYC system clocks. A frame opened earlier than that is refused until select rises again.
- R9: While select is high, the clock and data-in lines have no effect and `spi_sdo_en` is low.
- R10: While `sleep_n` is low or `chip_rst` is high, the port produces no strobes and does not drive data out.
- R11: A frame holds one register exchange. Bytes that follow a completed register write or read in the same frame are ignored.
- R12: `spi_sdo_en` is high only while select is low and the port is in a read or burst data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| sleep_n | input | 1 | Low = power-down, port held off |
| chip_rst | input | 1 | High = chip reset, port held off |
| spi_sck | input | 1 | Serial clock from host, idles high |
| spi_cs_n | input | 1 | Active-low select from host |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host |
| spi_sdo_en | output | 1 | Output enable for the data-out pad |
| busy | output | 1 | Read wait in progress |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 7 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid while `reg_rd` is high |
| mem_we | output | 1 | Download memory write strobe |
| mem_wdata | output | 8 | Download byte |

## Verification
The assertions assume that the serial lines change slowly compared with the system clock. Each half period of the serial clock must last several system clocks, and data in must be steady around each rising edge. They also assume that `sleep_n` and `chip_rst` are synchronous to `clk`, and that the host waits out the read wait before it clocks data. The bench keeps within these limits. It holds every serial half period for eight system clocks, pauses longer than READ_WAIT before the data phase, and changes the gating inputs only on the falling edge of the system clock.

// File: rtl/sspi_pkg.sv
package sspi_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;

   typedef enum logic [3:0] {
      ST_IDLE, ST_CMD, ST_RWAIT, ST_RDATA, ST_WDATA,
      ST_BWAIT, ST_BURST, ST_DLOAD, ST_LOCK, ST_GAP
   } sspi_state_e;
endpackage

// File: rtl/sspi_sync.sv
module sspi_sync #(
   parameter int WIDTH = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("sspi_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sspi_shift.sv
module sspi_shift
   import sspi_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              rise,
   input  logic              fall,
   input  logic              sdi,
   input  logic              tx_en,
   input  logic              tx_load,
   input  logic [BYTE_W-1:0] tx_data,
   output logic [BYTE_W-1:0] rx_next,
   output logic              byte_done,
   output logic              sdo
);
   logic [BYTE_W-1:0] rx_q, tx_q;
   logic [2:0]        cnt_q;
   logic              sdo_q;

   assign rx_next   = {rx_q[BYTE_W-2:0], sdi};
   assign byte_done = rise && (cnt_q == 3'd7);
   assign sdo       = sdo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q  <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (rise) begin
         rx_q  <= rx_next;
         cnt_q <= cnt_q + 3'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q  <= '0;
         sdo_q <= 1'b0;
      end else if (tx_load) begin
         tx_q <= tx_data;
      end else if (fall && tx_en) begin
         sdo_q <= tx_q[BYTE_W-1];
         tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
      end
   end

   // R3: data out moves only on a falling serial edge in a data phase
   p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(fall && tx_en) |=> $stable(sdo_q));
endmodule

// File: rtl/sspi_ctrl.sv
module sspi_ctrl
   import sspi_pkg::*;
#(
   parameter int READ_WAIT = 20,
   parameter int GAP_CYC = 16,
   parameter logic [6:0] BURST_ADDR = 7'h50,
   parameter logic [6:0] DL_ADDR = 7'h62,
   parameter logic [6:0] MOTION_BASE = 7'h02,
   parameter int MOTION_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_ok,
   input  logic              sel,
   input  logic              byte_done,
   input  logic [BYTE_W-1:0] rx_next,
   output logic              clr,
   output logic              accept,
   output logic              tx_en,
   output logic              busy,
   output logic              drive,
   output logic              reg_wr,
   output logic              reg_rd,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              mem_we,
   output logic [BYTE_W-1:0] mem_wdata
);
   localparam int CNT_MAX = (READ_WAIT > GAP_CYC) ? READ_WAIT : GAP_CYC;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam int IDX_W   = (MOTION_LEN > 1) ? $clog2(MOTION_LEN) : 1;

   sspi_state_e       st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q, idx_nxt;
   logic [ADDR_W-1:0] addr_q;
   logic [BYTE_W-1:0] wdata_q, mdata_q;
   logic              wr_q, rd_q, we_q;
   logic              active;

   generate
      if (MOTION_LEN > 1 && (MOTION_LEN & (MOTION_LEN - 1)) == 0) begin : g_wrap_pow2
         assign idx_nxt = idx_q + 1'b1;
      end else begin : g_wrap_cmp
         assign idx_nxt = (idx_q == IDX_W'(MOTION_LEN - 1)) ? '0 : idx_q + 1'b1;
      end
   endgenerate

   assign active = st_q inside {ST_CMD, ST_RWAIT, ST_RDATA, ST_WDATA,
                                ST_BWAIT, ST_BURST, ST_DLOAD};
   assign tx_en  = (st_q == ST_RDATA) || (st_q == ST_BURST);
   assign busy   = (st_q == ST_RWAIT) || (st_q == ST_BWAIT);
   assign accept = sel && port_ok &&
                   (st_q inside {ST_CMD, ST_RDATA, ST_WDATA, ST_BURST, ST_DLOAD});
   assign clr    = !accept;
   assign drive  = sel && port_ok && tx_en;

   assign reg_wr    = wr_q;
   assign reg_rd    = rd_q;
   assign reg_addr  = addr_q;
   assign reg_wdata = wdata_q;
   assign mem_we    = we_q;
   assign mem_wdata = mdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         mdata_q <= '0;
         wr_q    <= 1'b0;
         rd_q    <= 1'b0;
         we_q    <= 1'b0;
      end else begin
         wr_q <= 1'b0;
         rd_q <= 1'b0;
         we_q <= 1'b0;
         if (!port_ok || (!sel && active)) begin
            st_q  <= ST_GAP;
            cnt_q <= '0;
         end else begin
            case (st_q)
               ST_IDLE: if (sel) st_q <= ST_CMD;
               ST_CMD: if (byte_done) begin
                  addr_q <= rx_next[ADDR_W-1:0];
                  cnt_q  <= '0;
                  if (!rx_next[BYTE_W-1])                   st_q <= ST_RWAIT;
                  else if (rx_next[ADDR_W-1:0] == BURST_ADDR) begin
                     st_q  <= ST_BWAIT;
                     idx_q <= '0;
                  end
                  else if (rx_next[ADDR_W-1:0] == DL_ADDR)  st_q <= ST_DLOAD;
                  else                                      st_q <= ST_WDATA;
               end
               ST_RWAIT, ST_BWAIT: begin
                  if (cnt_q == CNT_W'(READ_WAIT - 1)) begin
                     rd_q <= 1'b1;
                     if (st_q == ST_BWAIT) begin
                        addr_q <= MOTION_BASE;
                        st_q   <= ST_BURST;
                     end else begin
                        st_q <= ST_RDATA;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_RDATA: if (byte_done) st_q <= ST_LOCK;
               ST_WDATA: if (byte_done) begin
                  wr_q    <= 1'b1;
                  wdata_q <= rx_next;
                  st_q    <= ST_LOCK;
               end
               ST_BURST: if (byte_done) begin
                  idx_q  <= idx_nxt;
                  addr_q <= MOTION_BASE + ADDR_W'(idx_nxt);
                  rd_q   <= 1'b1;
               end
               ST_DLOAD: if (byte_done) begin
                  we_q    <= 1'b1;
                  mdata_q <= rx_next;
               end
               ST_LOCK: if (!sel) begin
                  st_q  <= ST_GAP;
                  cnt_q <= '0;
               end
               ST_GAP: begin
                  if (sel)                                st_q <= ST_LOCK;
                  else if (cnt_q == CNT_W'(GAP_CYC - 1))  st_q <= ST_IDLE;
                  else                                    cnt_q <= cnt_q + 1'b1;
               end
               default: st_q <= ST_GAP;
            endcase
         end
      end
   end

   // R2: at most one bus strobe per cycle
   p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_q, rd_q, we_q}));

   // R10: a gated port raises no strobe in the next cycle
   p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !port_ok |=> !(wr_q || rd_q || we_q));

   // R7: deselect during an exchange lands in the idle gap
   p_deselect_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && active) |=> (st_q == ST_GAP));

   // R8: the gap never leads straight into a command
   p_gap_no_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_GAP) |=> (st_q inside {ST_GAP, ST_LOCK, ST_IDLE}));
endmodule

// File: rtl/sspi_regport.sv
module sspi_regport
   import sspi_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int READ_WAIT = 20,
   parameter int GAP_CYC = 16,
   parameter logic [6:0] BURST_ADDR = 7'h50,
   parameter logic [6:0] DL_ADDR = 7'h62,
   parameter logic [6:0] MOTION_BASE = 7'h02,
   parameter int MOTION_LEN = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_n,
   input  logic       chip_rst,
   input  logic       spi_sck,
   input  logic       spi_cs_n,
   input  logic       spi_sdi,
   output logic       spi_sdo,
   output logic       spi_sdo_en,
   output logic       busy,
   output logic       reg_wr,
   output logic       reg_rd,
   output logic [6:0] reg_addr,
   output logic [7:0] reg_wdata,
   input  logic [7:0] reg_rdata,
   output logic       mem_we,
   output logic [7:0] mem_wdata
);
   generate
      if (READ_WAIT < 1 || GAP_CYC < 1 || MOTION_LEN < 1 || SYNC_STAGES < 2)
      begin : g_bad_param
         $error("sspi_regport: illegal parameter value");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic              sck_s, cs_n_s, sdi_s, sck_d;
   logic              rise, fall, rise_g, fall_g;
   logic              port_ok, sel;
   logic              clr, accept, tx_en;
   logic              byte_done;
   logic [BYTE_W-1:0] rx_next;

   sspi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({spi_sck, spi_cs_n, spi_sdi}), .q(pins_s));

   assign {sck_s, cs_n_s, sdi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b1;
      else        sck_d <= sck_s;
   end

   assign rise    = sck_s && !sck_d;
   assign fall    = !sck_s && sck_d;
   assign port_ok = sleep_n && !chip_rst;
   assign sel     = !cs_n_s;
   assign rise_g  = rise && accept;
   assign fall_g  = fall && accept;

   sspi_shift u_shift (
      .clk(clk), .rst_n(rst_n), .clr(clr), .rise(rise_g), .fall(fall_g),
      .sdi(sdi_s), .tx_en(tx_en), .tx_load(reg_rd), .tx_data(reg_rdata),
      .rx_next(rx_next), .byte_done(byte_done), .sdo(spi_sdo));

   sspi_ctrl #(
      .READ_WAIT(READ_WAIT), .GAP_CYC(GAP_CYC), .BURST_ADDR(BURST_ADDR),
      .DL_ADDR(DL_ADDR), .MOTION_BASE(MOTION_BASE), .MOTION_LEN(MOTION_LEN)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .port_ok(port_ok), .sel(sel),
      .byte_done(byte_done), .rx_next(rx_next), .clr(clr), .accept(accept),
      .tx_en(tx_en), .busy(busy), .drive(spi_sdo_en), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .mem_we(mem_we), .mem_wdata(mem_wdata));

   // R4: no serial edge is taken while the read wait runs
   p_busy_blocks_edges_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(rise_g || fall_g));

   // R9: pad enable only while the synchronised select is low
   p_sdo_en_selected_r9: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sdo_en |-> (sel && port_ok));
endmodule

// File: tb/sspi_regport_bench.sv
module sspi_regport_bench;
   localparam int H = 8;
   localparam int READ_WAIT = 20;
   localparam int GAP_CYC = 16;
   localparam logic [6:0] BURST_ADDR = 7'h50;
   localparam logic [6:0] DL_ADDR = 7'h62;
   localparam logic [6:0] MOTION_BASE = 7'h02;
   localparam int MOTION_LEN = 4;

   // {write flag, address, data}
   localparam logic [15:0] VEC [0:5] = '{16'h923C, 16'h1200, 16'hFFA5,
                                         16'h0000, 16'h815A, 16'h7F00};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_n = 1'b1, chip_rst = 1'b0;
   logic sck = 1'b1, cs_n = 1'b1, sdi = 1'b0;
   logic sdo, sdo_en, busy, reg_wr, reg_rd, mem_we;
   logic [6:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata, mem_wdata;

   int n_chk = 0, n_fail = 0;
   int wr_cnt = 0, rd_cnt = 0, dl_cnt = 0;
   logic [6:0] last_wa, last_ra;
   logic [7:0] last_wd;
   logic [7:0] dl_log [0:7];
   bit done = 0;

   always #4 clk = ~clk;

   function automatic logic [7:0] resp(input logic [6:0] a);
      logic [7:0] x;
      x = {1'b0, a};
      return 8'(x * 8'd3 + 8'h11);
   endfunction

   assign reg_rdata = resp(reg_addr);

   sspi_regport u_sspi_regport (
      .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .chip_rst(chip_rst),
      .spi_sck(sck), .spi_cs_n(cs_n), .spi_sdi(sdi), .spi_sdo(sdo),
      .spi_sdo_en(sdo_en), .busy(busy), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_we(mem_we), .mem_wdata(mem_wdata));

   always @(posedge clk) begin
      if (reg_wr) begin wr_cnt <= wr_cnt + 1; last_wa <= reg_addr; last_wd <= reg_wdata; end
      if (reg_rd) begin rd_cnt <= rd_cnt + 1; last_ra <= reg_addr; end
      if (mem_we) begin dl_log[dl_cnt[2:0]] <= mem_wdata; dl_cnt <= dl_cnt + 1; end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic xfer_bits(input logic [7:0] b, input int n, output logic [7:0] r);
      r = '0;
      for (int i = 7; i > 7 - n; i--) begin
         @(negedge clk); sck = 1'b0; sdi = b[i];
         repeat (H) @(negedge clk);
         r[i] = sdo; sck = 1'b1;
         repeat (H) @(negedge clk);
      end
   endtask

   task automatic xfer(input logic [7:0] b, output logic [7:0] r);
      xfer_bits(b, 8, r);
   endtask

   task automatic sel_on();
      @(negedge clk); cs_n = 1'b0;
      repeat (H) @(negedge clk);
   endtask

   task automatic sel_off();
      @(negedge clk); cs_n = 1'b1;
      repeat (GAP_CYC + 12) @(negedge clk);
   endtask

   task automatic do_write(input logic [6:0] a, input logic [7:0] d);
      logic [7:0] r;
      sel_on(); xfer({1'b1, a}, r); xfer(d, r); sel_off();
   endtask

   task automatic do_read(input logic [6:0] a, output logic [7:0] d,
                          output logic bsy, output logic en);
      logic [7:0] r;
      sel_on(); xfer({1'b0, a}, r);
      bsy = busy;
      repeat (READ_WAIT + 6) @(negedge clk);
      en = sdo_en;
      xfer(8'h00, d); sel_off();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] r, d;
      logic bsy, en;
      int w0, d0;
      repeat (5) @(negedge clk);
      // R1: reset state
      chk("R1 sdo_en", sdo_en, 0);
      chk("R1 busy", busy, 0);
      chk("R1 strobes", {reg_wr, reg_rd, mem_we}, 0);
      rst_n = 1'b1;
      repeat (GAP_CYC + 4) @(negedge clk);

      // R2/R3/R4/R12: table walk
      foreach (VEC[i]) begin
         if (VEC[i][15]) begin
            w0 = wr_cnt;
            do_write(VEC[i][14:8], VEC[i][7:0]);
            chk("R2 write count", wr_cnt - w0, 1);
            chk("R2 write addr", last_wa, VEC[i][14:8]);
            chk("R2 write data", last_wd, VEC[i][7:0]);
         end else begin
            w0 = rd_cnt;
            do_read(VEC[i][14:8], d, bsy, en);
            chk("R3 read strobe", rd_cnt - w0, 1);
            chk("R3 read addr", last_ra, VEC[i][14:8]);
            chk("R3 read data", d, resp(VEC[i][14:8]));
            chk("R4 busy in wait", bsy, 1);
            chk("R12 sdo_en in data", en, 1);
            chk("R12 sdo_en after", sdo_en, 0);
         end
      end

      // R5: burst wraps through the motion registers
      sel_on(); xfer({1'b1, BURST_ADDR}, r);
      repeat (READ_WAIT + 6) @(negedge clk);
      for (int k = 0; k < 6; k++) begin
         xfer(8'h00, r);
         chk("R5 burst byte", r, resp(MOTION_BASE + 7'(k % MOTION_LEN)));
      end
      sel_off();
      chk("R12 sdo_en after burst", sdo_en, 0);

      // R6: download, partial tail dropped
      d0 = dl_cnt;
      sel_on(); xfer({1'b1, DL_ADDR}, r);
      xfer(8'h11, r); xfer(8'h22, r); xfer(8'hEE, r);
      xfer_bits(8'hFF, 5, r);
      sel_off();
      chk("R6 download count", dl_cnt - d0, 3);
      chk("R6 download first", dl_log[d0[2:0]], 8'h11);
      chk("R6 download last", dl_log[3'(d0 + 2)], 8'hEE);

      // R7: abort mid data byte
      w0 = wr_cnt;
      sel_on(); xfer(8'hA2, r); xfer_bits(8'hF0, 4, r); sel_off();
      chk("R7 aborted write", wr_cnt - w0, 0);
      do_write(7'h22, 8'h99);
      chk("R7 next write data", last_wd, 8'h99);

      // R8: select lowered inside the gap is refused
      w0 = wr_cnt;
      sel_on(); xfer(8'hB3, r); xfer(8'h44, r);
      @(negedge clk); cs_n = 1'b1;
      repeat (4) @(negedge clk); cs_n = 1'b0;
      repeat (H) @(negedge clk);
      xfer(8'hB3, r); xfer(8'h55, r); sel_off();
      chk("R8 refused frame", wr_cnt - w0, 1);
      chk("R8 data kept", last_wd, 8'h44);

      // R9: clock and data ignored while deselected
      w0 = wr_cnt;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk); sck = 1'b0; sdi = k[0];
         repeat (H) @(negedge clk);
         if (sdo_en) en = 1'b1;
         sck = 1'b1;
         repeat (H) @(negedge clk);
      end
      chk("R9 no strobe", wr_cnt - w0, 0);
      chk("R9 sdo_en low", sdo_en, 0);
      do_write(7'h30, 8'h6C);
      chk("R9 clean write", {last_wa, last_wd}, {7'h30, 8'h6C});

      // R10: power-down and chip reset gate the port
      w0 = wr_cnt;
      sleep_n = 1'b0; do_write(7'h31, 8'h01);
      chk("R10 power-down write", wr_cnt - w0, 0);
      sleep_n = 1'b1; chip_rst = 1'b1;
      sel_on(); xfer(8'h12, r); repeat (READ_WAIT + 6) @(negedge clk);
      chk("R10 reset no drive", sdo_en, 0);
      sel_off();
      chk("R10 reset no read", {reg_rd, busy}, 0);
      chip_rst = 1'b0;
      repeat (GAP_CYC + 4) @(negedge clk);
      do_write(7'h31, 8'h02);
      chk("R10 resumed", wr_cnt - w0, 1);

      // R11: extra byte in the same frame ignored
      w0 = wr_cnt;
      sel_on(); xfer(8'hC4, r); xfer(8'h77, r); xfer(8'hC5, r); xfer(8'h88, r); sel_off();
      chk("R11 one per frame", wr_cnt - w0, 1);
      chk("R11 first data", {last_wa, last_wd}, {7'h44, 8'h77});

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule